// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of level-sensitive peripheral interrupt lines and a small processor core. Each source has an enable bit and a two-bit priority, 0 being the least urgent and 3 the most urgent. From the requests that are enabled and not masked, the controller picks one. It gives the core a one-cycle request pulse and a vector address, and it keeps that address steady until the core acknowledges.

The controller masks by priority level. When the core acknowledges, the current mask goes onto a four-entry stack, and the mask then blocks the accepted level and every level below it. Only a strictly more urgent request can interrupt the running handler. A return pulse from the core pops the stack and restores the earlier mask. A request that is masked stays pending and is taken once its level opens again. The controller never clears a request itself, because the peripheral holds its line until software clears the peripheral's flag.

Two fast slots can each name one source. When that source wins, the vector is the slot's programmed handler address and not a table entry. A fast slot only takes effect if its source is at level 2. A slot that names a source at any other level raises a configuration-error flag, and that source is then vectored through the table as normal. A write-only register port programs all of the settings.

Top module: `prio_nest_intc`

## Requirements
- R1: After reset, irqReq is 0, maskLevel is 0, cfgErr and rtiErr are 0, every source is disabled and both fast slots are invalid.
- R2: A source is a candidate only if its srcReq bit is 1, its enable bit is set, and its priority is at least maskLevel. maskLevel 0 means idle, with every level allowed. maskLevel n+1 means a handler at level n is active. A request from a disabled source never produces irqReq.
- R3: Among the candidates, the one with the highest priority wins. When several share that priority, the lowest source index wins.
- R4: The vector of a normal (non-fast) winner is tableBase + index * 4. The write port sets tableBase at address NUM_SRC.
- R5: When the controller is not waiting for an acknowledge and a candidate exists at a clock edge, irqReq is 1 for exactly the following cycle. irqVector then holds that winner's vector until irqAck is seen, and no further pulse is issued before irqAck.
- R6: At the clock edge where irqAck is taken, the previous maskLevel is pushed and maskLevel becomes the accepted priority + 1. Requests at that level or below then stay pending without a pulse, and they are taken after returns lower the mask.
- R7: A candidate at a strictly higher priority than the active handler is accepted, and after its acknowledge maskLevel rises further.
- R8: A rtiPulse with a non-empty stack restores maskLevel, at that clock edge, to the value it had before the matching acknowledge.
- R9: A rtiPulse with an empty stack leaves maskLevel unchanged and sets rtiErr. rtiErr stays set until reset.
- R10: A valid fast slot whose source has priority 2 replaces that source's vector with the slot's handler address. When both slots name the same source, slot 0 wins. The register map is as follows. Source control is at addresses 0 to NUM_SRC-1, with bit 0 as enable and bits 2:1 as priority. Slot s source is at address NUM_SRC+1+s, with bit 15 as valid and the low bits as the source index. Slot s handler address is at address NUM_SRC+3+s.
- R11: cfgErr is 1 while any valid fast slot names a source whose priority is not 2, and that source then gets its normal table vector.
- R12: Four nested acceptances, at levels 0, 1, 2 and 3, fit the stack. Four returns then step maskLevel back through 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| srcReq | input | NUM_SRC | Level-sensitive request lines, one per source |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | CFG_AW | Register write address |
| cfgData | input | ADDR_W | Register write data |
| irqAck | input | 1 | Core accepts the pending request |
| rtiPulse | input | 1 | Core returns from a handler |
| irqReq | output | 1 | One-cycle request pulse to the core |
| irqVector | output | ADDR_W | Handler address, held until acknowledged |
| maskLevel | output | 3 | 0 when idle, otherwise active level + 1 |
| cfgErr | output | 1 | A fast slot names a source whose priority is not 2 |
| rtiErr | output | 1 | Sticky flag: a return came with an empty stack |

## Verification
A request driven while the controller is idle shows as irqReq and irqVector in the cycle that follows the next rising edge, and irqReq is low again one edge later. The bench therefore samples one time unit after each edge. The maskLevel change from an acknowledge or a return, and a rise of rtiErr, are visible right after the edge that takes the strobe. The bench drives every strobe for exactly one edge, starting at a falling edge, and reads the result at the next falling edge. cfgErr follows the configuration registers with no added delay, so the bench reads it one cycle after the write.

// File: rtl/prio_nest_intc_pkg.sv
package prio_nest_intc_pkg;
  typedef struct packed {
    logic issue;
    logic push;
    logic pop;
    logic rtiErrSet;
  } ctrlStrobes_t;

  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_t;

  localparam int MASK_W = 3;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import prio_nest_intc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hasWinner,
  input  logic         stackEmpty,
  input  logic         irqAck,
  input  logic         rtiPulse,
  output ctrlStrobes_t strb,
  output logic         irqReq,
  output logic         rtiErr,
  output logic         waiting
);
  ctrlState_t state;

  always_comb begin
    strb.issue     = (state == ST_IDLE) && hasWinner;
    strb.push      = (state == ST_WAIT) && irqAck;
    strb.pop       = rtiPulse && !strb.push && !stackEmpty;
    strb.rtiErrSet = rtiPulse && !strb.push && stackEmpty;
  end

  assign waiting = (state == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      irqReq <= 1'b0;
      rtiErr <= 1'b0;
    end else begin
      irqReq <= strb.issue;
      if (strb.issue)      state <= ST_WAIT;
      else if (strb.push)  state <= ST_IDLE;
      if (strb.rtiErrSet)  rtiErr <= 1'b1;
    end
  end

  // R5: request is a single-cycle pulse
  p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |=> !irqReq);

  // R5: no new pulse while an acknowledge is outstanding
  p_no_reissue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !irqAck) |=> !irqReq);

  // R9: return error is sticky
  p_rti_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rtiErr |=> rtiErr);
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import prio_nest_intc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int ADDR_W      = 16,
  parameter int ENTRY_BYTES = 4,
  parameter int NUM_FAST    = 2,
  parameter int STACK_DEPTH = 4,
  parameter int FAST_LEVEL  = 2,
  localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CFG_AW     = $clog2(NUM_SRC + 1 + 2 * NUM_FAST),
  localparam int SP_W       = $clog2(STACK_DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgData,
  input  ctrlStrobes_t      strb,
  output logic              hasWinner,
  output logic              stackEmpty,
  output logic [ADDR_W-1:0] irqVector,
  output logic [MASK_W-1:0] maskLevel,
  output logic              cfgErr
);
  localparam int BASE_ADDR     = NUM_SRC;
  localparam int SLOT_SRC_ADDR = NUM_SRC + 1;
  localparam int SLOT_VEC_ADDR = NUM_SRC + 1 + NUM_FAST;

  logic [NUM_SRC-1:0]  enReg;
  logic [1:0]          prioReg   [NUM_SRC];
  logic [ADDR_W-1:0]   tableBase;
  logic [SRC_W-1:0]    fastSrc   [NUM_FAST];
  logic [NUM_FAST-1:0] fastVld;
  logic [ADDR_W-1:0]   fastVec   [NUM_FAST];

  logic [MASK_W-1:0]   stackMem  [STACK_DEPTH];
  logic [SP_W-1:0]     sp;
  logic [MASK_W-1:0]   topVal;

  logic                found;
  logic [SRC_W-1:0]    bestIdx;
  logic [1:0]          bestPrio;
  logic [1:0]          pendLevel;
  logic [ADDR_W-1:0]   selVec;
  logic [NUM_FAST-1:0] fastOk;
  logic [NUM_FAST-1:0] slotBad;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg     <= '0;
      tableBase <= '0;
      fastVld   <= '0;
      for (int i = 0; i < NUM_SRC; i++) prioReg[i] <= '0;
      for (int s = 0; s < NUM_FAST; s++) begin
        fastSrc[s] <= '0;
        fastVec[s] <= '0;
      end
    end else if (cfgWrEn) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cfgAddr == CFG_AW'(i)) begin
          enReg[i]   <= cfgData[0];
          prioReg[i] <= cfgData[2:1];
        end
      end
      if (cfgAddr == CFG_AW'(BASE_ADDR)) tableBase <= cfgData;
      for (int s = 0; s < NUM_FAST; s++) begin
        if (cfgAddr == CFG_AW'(SLOT_SRC_ADDR + s)) begin
          fastVld[s] <= cfgData[ADDR_W-1];
          fastSrc[s] <= cfgData[SRC_W-1:0];
        end
        if (cfgAddr == CFG_AW'(SLOT_VEC_ADDR + s)) fastVec[s] <= cfgData;
      end
    end
  end

  // fast slot validity check against the named source's priority
  generate
    for (genvar s = 0; s < NUM_FAST; s++) begin : g_slot
      logic       inRange;
      logic [1:0] slotPrio;
      always_comb begin
        inRange  = 1'b0;
        slotPrio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
          if (fastSrc[s] == SRC_W'(i)) begin
            inRange  = 1'b1;
            slotPrio = prioReg[i];
          end
        end
        fastOk[s]  = fastVld[s] && inRange && (slotPrio == 2'(FAST_LEVEL));
        slotBad[s] = fastVld[s] && !fastOk[s];
      end
    end
  endgenerate

  assign cfgErr = |slotBad;

  // arbitration: highest level first, lowest index at ties
  always_comb begin
    found    = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcReq[i] && enReg[i] && ({1'b0, prioReg[i]} >= maskLevel)) begin
        if (!found || (prioReg[i] > bestPrio)) begin
          found    = 1'b1;
          bestIdx  = SRC_W'(i);
          bestPrio = prioReg[i];
        end
      end
    end
  end

  assign hasWinner = found;

  always_comb begin
    selVec = tableBase + ADDR_W'(bestIdx) * ADDR_W'(ENTRY_BYTES);
    for (int s = NUM_FAST - 1; s >= 0; s--) begin
      if (fastOk[s] && (fastSrc[s] == bestIdx)) selVec = fastVec[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqVector <= '0;
      pendLevel <= '0;
    end else if (strb.issue) begin
      irqVector <= selVec;
      pendLevel <= bestPrio;
    end
  end

  // mask stack
  always_comb begin
    topVal = '0;
    for (int k = 0; k < STACK_DEPTH; k++) begin
      if (sp == SP_W'(k + 1)) topVal = stackMem[k];
    end
  end

  assign stackEmpty = (sp == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp        <= '0;
      maskLevel <= '0;
      for (int k = 0; k < STACK_DEPTH; k++) stackMem[k] <= '0;
    end else if (strb.push) begin
      for (int k = 0; k < STACK_DEPTH; k++) begin
        if (sp == SP_W'(k)) stackMem[k] <= maskLevel;
      end
      sp        <= sp + 1'b1;
      maskLevel <= {1'b0, pendLevel} + 1'b1;
    end else if (strb.pop) begin
      sp        <= sp - 1'b1;
      maskLevel <= topVal;
    end
  end

  // R12: a push always finds a free stack entry
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    strb.push |-> (sp < SP_W'(STACK_DEPTH)));

  // R8: a return always lowers the mask
  p_pop_lowers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |=> (maskLevel < $past(maskLevel)));

  // R6: mask never leaves its encoding range
  p_mask_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    maskLevel <= 3'd4);
endmodule

// File: rtl/prio_nest_intc.sv
module prio_nest_intc
  import prio_nest_intc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int ADDR_W      = 16,
  parameter int ENTRY_BYTES = 4,
  parameter int NUM_FAST    = 2,
  parameter int STACK_DEPTH = 4,
  localparam int CFG_AW     = $clog2(NUM_SRC + 1 + 2 * NUM_FAST)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               cfgWrEn,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [ADDR_W-1:0]  cfgData,
  input  logic               irqAck,
  input  logic               rtiPulse,
  output logic               irqReq,
  output logic [ADDR_W-1:0]  irqVector,
  output logic [2:0]         maskLevel,
  output logic               cfgErr,
  output logic               rtiErr
);
  ctrlStrobes_t strb;
  logic hasWinner;
  logic stackEmpty;
  logic waiting;

  intc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hasWinner(hasWinner), .stackEmpty(stackEmpty),
    .irqAck(irqAck), .rtiPulse(rtiPulse), .strb(strb), .irqReq(irqReq),
    .rtiErr(rtiErr), .waiting(waiting)
  );

  intc_datapath #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES),
    .NUM_FAST(NUM_FAST), .STACK_DEPTH(STACK_DEPTH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .srcReq(srcReq), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .strb(strb), .hasWinner(hasWinner),
    .stackEmpty(stackEmpty), .irqVector(irqVector), .maskLevel(maskLevel),
    .cfgErr(cfgErr)
  );

  // R5: vector holds while the core has not acknowledged
  p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !irqAck) |=> $stable(irqVector));

  // R7: an acknowledge always raises the mask
  p_nest_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && irqAck) |=> (maskLevel > $past(maskLevel)));
endmodule

// File: tb/prio_nest_intc_tb_top.sv
module prio_nest_intc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  srcReq = '0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        irqAck = 1'b0;
  logic        rtiPulse = 1'b0;
  logic        irqReq;
  logic [15:0] irqVector;
  logic [2:0]  maskLevel;
  logic        cfgErr;
  logic        rtiErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic       tbEn   [NS];
  logic [1:0] tbPrio [NS];
  logic [15:0] tbBase;

  prio_nest_intc dut_i (
    .clk(clk), .rst_n(rst_n), .srcReq(srcReq), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .irqAck(irqAck), .rtiPulse(rtiPulse),
    .irqReq(irqReq), .irqVector(irqVector), .maskLevel(maskLevel),
    .cfgErr(cfgErr), .rtiErr(rtiErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int addr, input logic [15:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 4'(addr); cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setSrc(input int idx, input logic en, input logic [1:0] pr);
    tbEn[idx] = en; tbPrio[idx] = pr;
    cfgWrite(idx, {13'd0, pr, en});
  endtask

  task automatic setReq(input logic [7:0] r);
    @(negedge clk);
    srcReq = r;
  endtask

  task automatic expectPulse(input string tag, input logic [15:0] vec);
    @(posedge clk); #1;
    chk({tag, " pulse"}, 32'(irqReq), 1);
    chk({tag, " vector"}, 32'(irqVector), 32'(vec));
    @(posedge clk); #1;
    chk({tag, " pulse end"}, 32'(irqReq), 0);
    @(negedge clk);
  endtask

  task automatic expectQuiet(input string tag, input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      chk(tag, 32'(irqReq), 0);
    end
    @(negedge clk);
  endtask

  task automatic doAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic doRti();
    @(negedge clk); rtiPulse = 1'b1;
    @(negedge clk); rtiPulse = 1'b0;
  endtask

  function automatic int pickWinner(input logic [7:0] req, input int mask);
    int best = -1;
    for (int i = 0; i < NS; i++) begin
      if (req[i] && tbEn[i] && int'(tbPrio[i]) >= mask) begin
        if (best < 0 || tbPrio[i] > tbPrio[best]) best = i;
      end
    end
    return best;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin tbEn[i] = 1'b0; tbPrio[i] = 2'd0; end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irqReq", 32'(irqReq), 0);
    chk("R1 maskLevel", 32'(maskLevel), 0);
    chk("R1 cfgErr", 32'(cfgErr), 0);
    chk("R1 rtiErr", 32'(rtiErr), 0);
    rst_n = 1'b1;
    setReq(8'hFF);
    expectQuiet("R1 all disabled after reset", 3);
    setReq(8'h00);

    tbBase = 16'h1000;
    cfgWrite(NS, tbBase);
    setSrc(3, 1'b1, 2'd1);
    setSrc(5, 1'b1, 2'd1);
    setSrc(2, 1'b1, 2'd3);
    setSrc(6, 1'b0, 2'd3);

    // R2 disabled source ignored
    setReq(8'h40);
    expectQuiet("R2 disabled source", 4);

    // R3 tie at level 1, R4 table vector, R5 pulse
    setReq(8'h68);
    expectPulse("R3 R4 tie lowest index", 16'h100C);
    expectQuiet("R5 no reissue before ack", 3);
    doAck();
    chk("R6 mask after ack", 32'(maskLevel), 2);
    expectQuiet("R6 same level masked", 4);

    // R7 higher level nests
    setReq(8'h6C);
    expectPulse("R7 nest vector", 16'h1008);
    doAck();
    chk("R7 mask raised", 32'(maskLevel), 4);
    setReq(8'h68);
    doRti();
    chk("R8 mask restored", 32'(maskLevel), 2);
    expectQuiet("R6 still masked", 3);
    setReq(8'h60);
    doRti();
    chk("R8 mask back idle", 32'(maskLevel), 0);
    expectPulse("R6 pending taken", 16'h1014);
    doAck();
    chk("R6 mask second", 32'(maskLevel), 2);
    setReq(8'h00);
    doRti();
    chk("R8 idle again", 32'(maskLevel), 0);

    // R9 return with empty stack
    doRti();
    chk("R9 rtiErr", 32'(rtiErr), 1);
    chk("R9 mask unchanged", 32'(maskLevel), 0);
    repeat (3) @(negedge clk);
    chk("R9 rtiErr sticky", 32'(rtiErr), 1);

    // R10 fast slot
    setSrc(4, 1'b1, 2'd2);
    cfgWrite(NS + 1, 16'h8004);
    cfgWrite(NS + 3, 16'hBEE0);
    cfgWrite(NS + 2, 16'h8004);
    cfgWrite(NS + 4, 16'hCAF0);
    @(negedge clk);
    chk("R10 no cfgErr", 32'(cfgErr), 0);
    setReq(8'h10);
    expectPulse("R10 fast vector slot0 wins", 16'hBEE0);
    doAck();
    setReq(8'h00);
    doRti();

    // R11 wrong level on fast slot
    setSrc(4, 1'b1, 2'd1);
    @(negedge clk);
    chk("R11 cfgErr set", 32'(cfgErr), 1);
    setReq(8'h10);
    expectPulse("R11 normal vector", 16'h1010);
    doAck();
    setReq(8'h00);
    doRti();
    cfgWrite(NS + 1, 16'h0000);
    cfgWrite(NS + 2, 16'h0000);
    @(negedge clk);
    chk("R11 cfgErr cleared", 32'(cfgErr), 0);

    // R12 four-deep nesting
    for (int i = 0; i < NS; i++) setSrc(i, 1'b0, 2'd0);
    for (int l = 0; l < 4; l++) setSrc(l, 1'b1, 2'(l));
    for (int l = 0; l < 4; l++) begin
      setReq(8'(1 << l));
      expectPulse("R12 nest pulse", tbBase + 16'(l * 4));
      doAck();
      chk("R12 nest mask", 32'(maskLevel), 32'(l + 1));
    end
    setReq(8'h00);
    for (int l = 3; l >= 0; l--) begin
      doRti();
      chk("R12 unwind mask", 32'(maskLevel), 32'(l));
    end

    // random arbitration from idle
    for (int it = 0; it < 30; it++) begin
      logic [7:0] r;
      int w;
      tbBase = 16'($urandom) & 16'hFF00;
      cfgWrite(NS, tbBase);
      for (int i = 0; i < NS; i++) setSrc(i, 1'($urandom), 2'($urandom));
      r = 8'($urandom);
      w = pickWinner(r, 0);
      setReq(r);
      if (w >= 0) begin
        expectPulse("R3 R4 random", tbBase + 16'(w * 4));
        doAck();
        chk("R6 random mask", 32'(maskLevel), 32'(int'(tbPrio[w]) + 1));
        setReq(8'h00);
        doRti();
        chk("R8 random restore", 32'(maskLevel), 0);
      end else begin
        expectQuiet("R2 random none eligible", 3);
        setReq(8'h00);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule